// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block is a synthesizable behavioural model of an on-chip memory with two fully independent access ports, A and B. Each port reads or writes one word per rising clock edge through its own address, write data, byte-lane write enables, read enable and registered read data. The two ports see one shared bit array. Each may pick its own word width, as long as both widths belong to one width family. The power-of-two family (1, 2, 4, 8, 16 bits) covers a 16384-bit array. The five-based family (5, 10, 20 bits) covers a 20480-bit array.

A port narrower than another simply splits each wide word into several narrow words. Word k of a W-bit port always covers array bits k*W up to k*W+W-1, with its least significant bit at the lowest array position. Writes are masked per lane. A lane is 8 bits in the power-of-two family and 10 bits in the five-based family. Widths up to 10 carry one enable; widths 16 and 20 carry two, one per lane. The array can be preloaded from a parameter vector.

Each port's read-data register acts as a small state holder. It has three selectable behaviours when that port writes while its read enable is high. In HOLD it keeps its present value. In NEW it takes the word as it stands after the write. In OLD it takes the word as it stood before the write. When the read enable is high with no write, the register loads the stored word. When the read enable is low, the register keeps its value. Reset clears only the read registers.

Top module: `mw_tdp_ram`

## Requirements
- R1: While rst_n is low, a_rdata and b_rdata are all zeros. The array contents are not changed by reset.
- R2: Array bit i holds INIT_BITS[i] at time zero, and a read of any word returns those preloaded bits until the word is written.
- R3: Word k of a port of width W maps to array bits k*W through k*W+W-1, with data bit 0 at array bit k*W. This holds across ports of different widths, so a 16-bit word k equals the 8-bit words 2k (low byte) and 2k+1 (high byte).
- R4: Widths 16 and 20 have a two-bit enable. Bit j enables data bits j*L through j*L+L-1, where L is 8 in the power-of-two family and 10 in the five-based family. Lanes that are not enabled keep their contents. Narrower widths have a single enable that covers the whole word.
- R5: With the read enable low, a port's read data keeps its value even while that port writes, and the write still reaches the array.
- R6: Mode HOLD: a write with the read enable high leaves the port's read data unchanged.
- R7: Mode NEW: a write with the read enable high loads the read data with the word as it stands after the write, meaning new bits in enabled lanes and stored bits in the others.
- R8: Mode OLD: a write with the read enable high loads the read data with the word's contents from before the write.
- R9: A read (read enable high, no write) loads the read data with the stored word.
- R10: When one port writes bits that the other port reads in the same cycle, the reading port returns the contents from before the write. The new contents are visible from the next cycle.
- R11: Both ports act on the rising edge of the shared clk. Read data changes one edge after the request.
- R12: The five-based family packs 5-bit words four to a 20-bit word, in the order of R3, over a 20480-bit array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of both read registers |
| a_addr | input | log2(array bits / WIDTH_A) | Port A word address |
| a_wdata | input | WIDTH_A | Port A write data |
| a_we | input | 1 or 2 | Port A lane write enables |
| a_ren | input | 1 | Port A read enable |
| a_rdata | output | WIDTH_A | Port A registered read data |
| b_addr | input | log2(array bits / WIDTH_B) | Port B word address |
| b_wdata | input | WIDTH_B | Port B write data |
| b_we | input | 1 or 2 | Port B lane write enables |
| b_ren | input | 1 | Port B read enable |
| b_rdata | output | WIDTH_B | Port B registered read data |

## Verification
The assertions assume that the two ports never write the same array bit in the same cycle. Under that assumption, a NEW-mode port writing all of its lanes must return exactly the data it wrote. They also assume the array holds defined values, which the preload guarantees, so a completed read never yields unknown bits. The directed stimulus keeps every simultaneous A/B access collision-free: same-cycle overlap is used only as a write on one port against a read on the other. Each write is applied to a bench-side bit array, and expected words are cut from that array by the mapping rule.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        WM_HOLD = 2'd0,
        WM_NEW  = 2'd1,
        WM_OLD  = 2'd2
    } wr_mode_e;

    typedef enum logic {
        FAM_POW2  = 1'b0,
        FAM_ALIGN = 1'b1
    } width_fam_e;

    localparam int MAX_BITS = 20480;

    function automatic int lane_bits(width_fam_e f);
        return (f == FAM_ALIGN) ? 10 : 8;
    endfunction

    function automatic int total_bits(width_fam_e f);
        return (f == FAM_ALIGN) ? 20480 : 16384;
    endfunction

    function automatic int addr_bits(width_fam_e f, int w);
        return $clog2(total_bits(f) / w);
    endfunction

    function automatic int en_bits(width_fam_e f, int w);
        return (w >= lane_bits(f)) ? (w / lane_bits(f)) : 1;
    endfunction

    function automatic bit width_ok(width_fam_e f, int w);
        if (f == FAM_ALIGN)
            return (w == 5) || (w == 10) || (w == 20);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

endpackage

// File: rtl/mw_addr_map.sv
module mw_addr_map #(
    parameter int W    = 8,
    parameter int LANE = 8,
    parameter int AW   = 11,
    parameter int LAW  = 11,
    parameter int NL   = 1
) (
    input  logic [AW-1:0]      addr,
    input  logic [W-1:0]       wdata,
    input  logic [NL-1:0]      we,
    input  logic [NL*LANE-1:0] old_lanes,
    output logic [LAW-1:0]     lane_base,
    output logic [NL*LANE-1:0] lane_mask,
    output logic [NL*LANE-1:0] lane_data,
    output logic [W-1:0]       old_word,
    output logic [W-1:0]       new_word
);

    logic [NL*LANE-1:0] merged;

    assign merged = (old_lanes & ~lane_mask) | (lane_data & lane_mask);

    generate
        if (W < LANE) begin : g_sub_lane
            localparam int WPL  = LANE / W;
            localparam int OFFW = $clog2(LANE);
            localparam logic [LANE-1:0] WMASK = LANE'((1 << W) - 1);

            logic [OFFW-1:0] bit_off;

            always_comb begin
                lane_base = LAW'(addr / AW'(WPL));
                bit_off   = OFFW'((addr % AW'(WPL)) * AW'(W));
                lane_mask = we[0] ? (WMASK << bit_off) : '0;
                lane_data = LANE'(wdata) << bit_off;
                old_word  = W'(old_lanes >> bit_off);
                new_word  = W'(merged >> bit_off);
            end
        end else begin : g_multi_lane
            always_comb begin
                lane_base = LAW'(32'(addr) * NL);
                lane_data = wdata;
                old_word  = old_lanes;
                new_word  = merged;
            end
            for (genvar j = 0; j < NL; j++) begin : g_lane
                assign lane_mask[j*LANE +: LANE] = {LANE{we[j]}};
            end
        end
    endgenerate

endmodule

// File: rtl/mw_rd_reg.sv
module mw_rd_reg #(
    parameter int               W    = 8,
    parameter mw_pkg::wr_mode_e MODE = mw_pkg::WM_HOLD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ren,
    input  logic         wr_act,
    input  logic [W-1:0] old_word,
    input  logic [W-1:0] new_word,
    output logic [W-1:0] rdata
);

    logic [W-1:0] rd_next;

    always_comb begin
        rd_next = rdata;
        if (ren) begin
            if (!wr_act) begin
                rd_next = old_word;
            end else begin
                unique case (MODE)
                    mw_pkg::WM_HOLD: rd_next = rdata;
                    mw_pkg::WM_NEW:  rd_next = new_word;
                    mw_pkg::WM_OLD:  rd_next = old_word;
                    default:         rd_next = rdata;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_next;
    end

endmodule

// File: rtl/mw_tdp_ram.sv
module mw_tdp_ram #(
    parameter mw_pkg::width_fam_e        FAMILY    = mw_pkg::FAM_POW2,
    parameter int                        WIDTH_A   = 8,
    parameter int                        WIDTH_B   = 16,
    parameter mw_pkg::wr_mode_e          MODE_A    = mw_pkg::WM_NEW,
    parameter mw_pkg::wr_mode_e          MODE_B    = mw_pkg::WM_OLD,
    parameter logic [mw_pkg::MAX_BITS-1:0] INIT_BITS = '0
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [mw_pkg::addr_bits(FAMILY, WIDTH_A)-1:0] a_addr,
    input  logic [WIDTH_A-1:0]                            a_wdata,
    input  logic [mw_pkg::en_bits(FAMILY, WIDTH_A)-1:0]   a_we,
    input  logic                                          a_ren,
    output logic [WIDTH_A-1:0]                            a_rdata,
    input  logic [mw_pkg::addr_bits(FAMILY, WIDTH_B)-1:0] b_addr,
    input  logic [WIDTH_B-1:0]                            b_wdata,
    input  logic [mw_pkg::en_bits(FAMILY, WIDTH_B)-1:0]   b_we,
    input  logic                                          b_ren,
    output logic [WIDTH_B-1:0]                            b_rdata
);

    localparam int LANE   = mw_pkg::lane_bits(FAMILY);
    localparam int NLANES = mw_pkg::total_bits(FAMILY) / LANE;
    localparam int LAW    = $clog2(NLANES);
    localparam int AWA    = mw_pkg::addr_bits(FAMILY, WIDTH_A);
    localparam int AWB    = mw_pkg::addr_bits(FAMILY, WIDTH_B);
    localparam int NLA    = mw_pkg::en_bits(FAMILY, WIDTH_A);
    localparam int NLB    = mw_pkg::en_bits(FAMILY, WIDTH_B);

    generate
        if (!mw_pkg::width_ok(FAMILY, WIDTH_A) || !mw_pkg::width_ok(FAMILY, WIDTH_B)) begin : g_bad_width
            $error("mw_tdp_ram: port widths must both belong to the chosen family");
        end
    endgenerate

    logic [LANE-1:0] mem [NLANES];

    initial begin
        for (int i = 0; i < NLANES; i++)
            mem[i] = INIT_BITS[i*LANE +: LANE];
    end

    logic [LAW-1:0]      a_base, b_base;
    logic [NLA*LANE-1:0] a_old_lanes, a_mask, a_data, a_wlane;
    logic [NLB*LANE-1:0] b_old_lanes, b_mask, b_data, b_wlane;
    logic [WIDTH_A-1:0]  a_old_word, a_new_word;
    logic [WIDTH_B-1:0]  b_old_word, b_new_word;

    always_comb begin
        for (int j = 0; j < NLA; j++)
            a_old_lanes[j*LANE +: LANE] = mem[a_base + LAW'(j)];
        for (int i = 0; i < NLB; i++)
            b_old_lanes[i*LANE +: LANE] = mem[b_base + LAW'(i)];
    end

    mw_addr_map #(
        .W(WIDTH_A), .LANE(LANE), .AW(AWA), .LAW(LAW), .NL(NLA)
    ) u_map_a (
        .addr(a_addr), .wdata(a_wdata), .we(a_we), .old_lanes(a_old_lanes),
        .lane_base(a_base), .lane_mask(a_mask), .lane_data(a_data),
        .old_word(a_old_word), .new_word(a_new_word)
    );

    mw_addr_map #(
        .W(WIDTH_B), .LANE(LANE), .AW(AWB), .LAW(LAW), .NL(NLB)
    ) u_map_b (
        .addr(b_addr), .wdata(b_wdata), .we(b_we), .old_lanes(b_old_lanes),
        .lane_base(b_base), .lane_mask(b_mask), .lane_data(b_data),
        .old_word(b_old_word), .new_word(b_new_word)
    );

    // Lane values to store: both ports' masks are folded into any shared lane
    // so that disjoint bits written by A and B in one lane both survive.
    always_comb begin
        logic [LANE-1:0] v;
        for (int j = 0; j < NLA; j++) begin
            v = a_old_lanes[j*LANE +: LANE];
            v = (v & ~a_mask[j*LANE +: LANE]) | (a_data[j*LANE +: LANE] & a_mask[j*LANE +: LANE]);
            for (int i = 0; i < NLB; i++) begin
                if (b_base + LAW'(i) == a_base + LAW'(j))
                    v = (v & ~b_mask[i*LANE +: LANE]) | (b_data[i*LANE +: LANE] & b_mask[i*LANE +: LANE]);
            end
            a_wlane[j*LANE +: LANE] = v;
        end
        for (int i = 0; i < NLB; i++) begin
            v = b_old_lanes[i*LANE +: LANE];
            for (int j = 0; j < NLA; j++) begin
                if (a_base + LAW'(j) == b_base + LAW'(i))
                    v = (v & ~a_mask[j*LANE +: LANE]) | (a_data[j*LANE +: LANE] & a_mask[j*LANE +: LANE]);
            end
            v = (v & ~b_mask[i*LANE +: LANE]) | (b_data[i*LANE +: LANE] & b_mask[i*LANE +: LANE]);
            b_wlane[i*LANE +: LANE] = v;
        end
    end

    always_ff @(posedge clk) begin
        if (|a_we) begin
            for (int j = 0; j < NLA; j++)
                mem[a_base + LAW'(j)] <= a_wlane[j*LANE +: LANE];
        end
        if (|b_we) begin
            for (int i = 0; i < NLB; i++)
                mem[b_base + LAW'(i)] <= b_wlane[i*LANE +: LANE];
        end
    end

    mw_rd_reg #(.W(WIDTH_A), .MODE(MODE_A)) u_rd_a (
        .clk(clk), .rst_n(rst_n), .ren(a_ren), .wr_act(|a_we),
        .old_word(a_old_word), .new_word(a_new_word), .rdata(a_rdata)
    );

    mw_rd_reg #(.W(WIDTH_B), .MODE(MODE_B)) u_rd_b (
        .clk(clk), .rst_n(rst_n), .ren(b_ren), .wr_act(|b_we),
        .old_word(b_old_word), .new_word(b_new_word), .rdata(b_rdata)
    );

endmodule

// File: rtl/mw_tdp_ram_chk.sv
module mw_tdp_ram_chk #(
    parameter mw_pkg::width_fam_e FAMILY  = mw_pkg::FAM_POW2,
    parameter int                 WIDTH_A = 8,
    parameter int                 WIDTH_B = 16,
    parameter mw_pkg::wr_mode_e   MODE_A  = mw_pkg::WM_NEW,
    parameter mw_pkg::wr_mode_e   MODE_B  = mw_pkg::WM_OLD
) (
    input logic                                        clk,
    input logic                                        rst_n,
    input logic [WIDTH_A-1:0]                          a_wdata,
    input logic [mw_pkg::en_bits(FAMILY, WIDTH_A)-1:0] a_we,
    input logic                                        a_ren,
    input logic [WIDTH_A-1:0]                          a_rdata,
    input logic [WIDTH_B-1:0]                          b_wdata,
    input logic [mw_pkg::en_bits(FAMILY, WIDTH_B)-1:0] b_we,
    input logic                                        b_ren,
    input logic [WIDTH_B-1:0]                          b_rdata
);

    // R5: read register idles when read enable is low
    assert_idle_hold_R5_a: assert property (@(posedge clk) disable iff (!rst_n)
        !a_ren |=> $stable(a_rdata));
    assert_idle_hold_R5_b: assert property (@(posedge clk) disable iff (!rst_n)
        !b_ren |=> $stable(b_rdata));

    // R9: a completed read returns defined bits
    assert_read_known_R9_a: assert property (@(posedge clk) disable iff (!rst_n)
        a_ren |=> !$isunknown(a_rdata));
    assert_read_known_R9_b: assert property (@(posedge clk) disable iff (!rst_n)
        b_ren |=> !$isunknown(b_rdata));

    generate
        if (MODE_A == mw_pkg::WM_HOLD) begin : g_a_hold
            assert_hold_mode_R6_a: assert property (@(posedge clk) disable iff (!rst_n)
                (a_ren && (|a_we)) |=> $stable(a_rdata));
        end else if (MODE_A == mw_pkg::WM_NEW) begin : g_a_new
            assert_new_mode_R7_a: assert property (@(posedge clk) disable iff (!rst_n)
                (a_ren && (&a_we)) |=> (a_rdata == $past(a_wdata)));
        end
        if (MODE_B == mw_pkg::WM_HOLD) begin : g_b_hold
            assert_hold_mode_R6_b: assert property (@(posedge clk) disable iff (!rst_n)
                (b_ren && (|b_we)) |=> $stable(b_rdata));
        end else if (MODE_B == mw_pkg::WM_NEW) begin : g_b_new
            assert_new_mode_R7_b: assert property (@(posedge clk) disable iff (!rst_n)
                (b_ren && (&b_we)) |=> (b_rdata == $past(b_wdata)));
        end
    endgenerate

endmodule

bind mw_tdp_ram mw_tdp_ram_chk #(
    .FAMILY(FAMILY), .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B),
    .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_wdata(a_wdata), .a_we(a_we), .a_ren(a_ren), .a_rdata(a_rdata),
    .b_wdata(b_wdata), .b_we(b_we), .b_ren(b_ren), .b_rdata(b_rdata)
);

// File: tb/tb_mw_tdp_ram.sv
module tb_mw_tdp_ram;

    localparam int CLK_PERIOD = 10;
    localparam logic [20479:0] INIT_P = {1280{16'hC3A5}};
    localparam logic [20479:0] INIT_Q = {2048{10'h2B6}};

    logic clk   = 1'b0;
    logic rst_n = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [10:0] pa_addr = '0;  logic [7:0]  pa_wdata = '0; logic [0:0] pa_we = '0;
    logic        pa_ren  = 1'b0; logic [7:0] pa_rdata;
    logic [9:0]  pb_addr = '0;  logic [15:0] pb_wdata = '0; logic [1:0] pb_we = '0;
    logic        pb_ren  = 1'b0; logic [15:0] pb_rdata;
    logic [11:0] qa_addr = '0;  logic [4:0]  qa_wdata = '0; logic [0:0] qa_we = '0;
    logic        qa_ren  = 1'b0; logic [4:0] qa_rdata;
    logic [9:0]  qb_addr = '0;  logic [19:0] qb_wdata = '0; logic [1:0] qb_we = '0;
    logic        qb_ren  = 1'b0; logic [19:0] qb_rdata;

    int n_checks = 0;
    int n_err    = 0;
    logic [16383:0] ref_p = INIT_P[16383:0];
    logic [20479:0] ref_q = INIT_Q;

    mw_tdp_ram #(
        .FAMILY(mw_pkg::FAM_POW2), .WIDTH_A(8), .WIDTH_B(16),
        .MODE_A(mw_pkg::WM_NEW), .MODE_B(mw_pkg::WM_OLD), .INIT_BITS(INIT_P)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(pa_addr), .a_wdata(pa_wdata), .a_we(pa_we), .a_ren(pa_ren), .a_rdata(pa_rdata),
        .b_addr(pb_addr), .b_wdata(pb_wdata), .b_we(pb_we), .b_ren(pb_ren), .b_rdata(pb_rdata)
    );

    mw_tdp_ram #(
        .FAMILY(mw_pkg::FAM_ALIGN), .WIDTH_A(5), .WIDTH_B(20),
        .MODE_A(mw_pkg::WM_HOLD), .MODE_B(mw_pkg::WM_NEW), .INIT_BITS(INIT_Q)
    ) dut_al (
        .clk(clk), .rst_n(rst_n),
        .a_addr(qa_addr), .a_wdata(qa_wdata), .a_we(qa_we), .a_ren(qa_ren), .a_rdata(qa_rdata),
        .b_addr(qb_addr), .b_wdata(qb_wdata), .b_we(qb_we), .b_ren(qb_ren), .b_rdata(qb_rdata)
    );

    function automatic logic [7:0]  p_a(int a); return ref_p[a*8 +: 8];   endfunction
    function automatic logic [15:0] p_b(int a); return ref_p[a*16 +: 16]; endfunction
    function automatic logic [4:0]  q_a(int a); return ref_q[a*5 +: 5];   endfunction
    function automatic logic [19:0] q_b(int a); return ref_q[a*20 +: 20]; endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_pa(input int a, input logic [7:0] d, input logic w, input logic r);
        pa_addr = 11'(a); pa_wdata = d; pa_we = w; pa_ren = r;
    endtask
    task automatic set_pb(input int a, input logic [15:0] d, input logic [1:0] w, input logic r);
        pb_addr = 10'(a); pb_wdata = d; pb_we = w; pb_ren = r;
    endtask
    task automatic set_qa(input int a, input logic [4:0] d, input logic w, input logic r);
        qa_addr = 12'(a); qa_wdata = d; qa_we = w; qa_ren = r;
    endtask
    task automatic set_qb(input int a, input logic [19:0] d, input logic [1:0] w, input logic r);
        qb_addr = 10'(a); qb_wdata = d; qb_we = w; qb_ren = r;
    endtask

    // One rising edge for both instances, then mirror the writes into the references.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (pa_we[0]) ref_p[int'(pa_addr)*8 +: 8] = pa_wdata;
        for (int j = 0; j < 2; j++)
            if (pb_we[j]) ref_p[int'(pb_addr)*16 + j*8 +: 8] = pb_wdata[j*8 +: 8];
        if (qa_we[0]) ref_q[int'(qa_addr)*5 +: 5] = qa_wdata;
        for (int j = 0; j < 2; j++)
            if (qb_we[j]) ref_q[int'(qb_addr)*20 + j*10 +: 10] = qb_wdata[j*10 +: 10];
        pa_we = '0; pa_ren = 1'b0; pb_we = '0; pb_ren = 1'b0;
        qa_we = '0; qa_ren = 1'b0; qb_we = '0; qb_ren = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pow2 A rdata in reset",    32'(pa_rdata), 32'h0);
        check("R1 pow2 B rdata in reset",    32'(pb_rdata), 32'h0);
        check("R1 aligned A rdata in reset", 32'(qa_rdata), 32'h0);
        check("R1 aligned B rdata in reset", 32'(qb_rdata), 32'h0);
    endtask

    task automatic t_preload();
        set_pa(3, 8'h00, 1'b0, 1'b1);
        set_pb(7, 16'h0, 2'b00, 1'b1);
        set_qa(1, 5'h0, 1'b0, 1'b1);
        set_qb(4, 20'h0, 2'b00, 1'b1);
        tick();
        check("R2 preload A byte 3",           32'(pa_rdata), 32'(p_a(3)));
        check("R9 R11 read B word 7 one edge", 32'(pb_rdata), 32'h0000C3A5);
        check("R2 aligned A word 1",           32'(qa_rdata), 32'(q_a(1)));
        check("R2 aligned B word 4",           32'(qb_rdata), {12'h0, 20'(INIT_Q[80 +: 20])});
    endtask

    task automatic t_mapping();
        set_pa(40, 8'h11, 1'b1, 1'b0); tick();
        set_pa(41, 8'h22, 1'b1, 1'b0); tick();
        set_pb(20, 16'h0, 2'b00, 1'b1); tick();
        check("R3 two bytes form B word 20", 32'(pb_rdata), 32'h00002211);
        set_pb(30, 16'hA1B2, 2'b11, 1'b0); tick();
        set_pa(60, 8'h00, 1'b0, 1'b1); tick();
        check("R3 low byte of B word 30", 32'(pa_rdata), 32'h000000B2);
        set_pa(61, 8'h00, 1'b0, 1'b1); tick();
        check("R3 high byte of B word 30", 32'(pa_rdata), 32'h000000A1);
    endtask

    task automatic t_lanes();
        logic [9:0] lo_keep;
        set_pb(33, 16'h7E9C, 2'b10, 1'b0); tick();
        set_pb(33, 16'h0, 2'b00, 1'b1); tick();
        check("R4 high lane written", 32'(pb_rdata), 32'(p_b(33)));
        set_pa(66, 8'h00, 1'b0, 1'b1); tick();
        check("R4 low lane kept", 32'(pa_rdata), 32'h000000A5);
        lo_keep = q_b(6)[9:0];
        set_qb(6, 20'hABCDE, 2'b01, 1'b0); tick();
        set_qb(6, 20'h0, 2'b00, 1'b1); tick();
        check("R4 aligned low lane only", 32'(qb_rdata), 32'(q_b(6)));
        check("R4 aligned high lane kept", 32'(qb_rdata[19:10]), 32'(INIT_Q[130 +: 10]));
        check("R4 aligned low lane new", 32'(qb_rdata[9:0]), 32'h0DE);
        if (lo_keep == 10'h0DE) check("R4 lane pattern distinct", 32'h1, 32'h0);
    endtask

    task automatic t_ren();
        logic [7:0]  hold_a;
        logic [15:0] hold_b;
        set_pa(90, 8'h00, 1'b0, 1'b1);
        set_pb(91, 16'h0, 2'b00, 1'b1);
        tick();
        hold_a = pa_rdata;
        hold_b = pb_rdata;
        set_pa(90, 8'h6D, 1'b1, 1'b0);
        set_pb(91, 16'h4455, 2'b11, 1'b0);
        tick();
        check("R5 A holds during write with ren low", 32'(pa_rdata), 32'(hold_a));
        check("R5 B holds during write with ren low", 32'(pb_rdata), 32'(hold_b));
        set_pa(90, 8'h00, 1'b0, 1'b1);
        set_pb(91, 16'h0, 2'b00, 1'b1);
        tick();
        check("R5 A write reached array", 32'(pa_rdata), 32'h6D);
        check("R5 B write reached array", 32'(pb_rdata), 32'h4455);
    endtask

    task automatic t_modes();
        logic [15:0] old_b;
        logic [4:0]  hold_q;
        logic [9:0]  lo_q;
        set_pa(100, 8'h3C, 1'b1, 1'b1); tick();
        check("R7 NEW mode returns written byte", 32'(pa_rdata), 32'h3C);
        old_b = p_b(110);
        set_pb(110, 16'h1234, 2'b11, 1'b1); tick();
        check("R8 OLD mode returns prior word", 32'(pb_rdata), 32'(old_b));
        set_pb(110, 16'h0, 2'b00, 1'b1); tick();
        check("R8 OLD mode write stored", 32'(pb_rdata), 32'h1234);
        set_qa(20, 5'h0, 1'b0, 1'b1); tick();
        hold_q = qa_rdata;
        set_qa(21, 5'h0A, 1'b1, 1'b1); tick();
        check("R6 HOLD mode keeps read data", 32'(qa_rdata), 32'(hold_q));
        set_qa(21, 5'h0, 1'b0, 1'b1); tick();
        check("R6 HOLD mode write stored", 32'(qa_rdata), 32'h0A);
        lo_q = q_b(12)[9:0];
        set_qb(12, 20'h5A5A5, 2'b10, 1'b1); tick();
        check("R7 NEW mode partial lanes", 32'(qb_rdata), {12'h0, 10'h169, lo_q});
    endtask

    task automatic t_cross();
        logic [15:0] old_b;
        logic [19:0] old_q;
        old_b = p_b(40);
        set_pa(80, 8'hE7, 1'b1, 1'b0);
        set_pb(40, 16'h0, 2'b00, 1'b1);
        tick();
        check("R10 B sees old bits during A write", 32'(pb_rdata), 32'(old_b));
        set_pb(40, 16'h0, 2'b00, 1'b1); tick();
        check("R10 B sees new bits next cycle", 32'(pb_rdata[7:0]), 32'hE7);
        old_q = q_b(12);
        set_qa(50, 5'h13, 1'b1, 1'b0);
        set_qb(12, 20'h0, 2'b00, 1'b1);
        tick();
        check("R10 aligned B sees old bits", 32'(qb_rdata), 32'(old_q));
    endtask

    task automatic t_aligned_map();
        set_qa(8,  5'h11, 1'b1, 1'b0); tick();
        set_qa(9,  5'h07, 1'b1, 1'b0); tick();
        set_qa(10, 5'h1E, 1'b1, 1'b0); tick();
        set_qa(11, 5'h03, 1'b1, 1'b0); tick();
        set_qb(2, 20'h0, 2'b00, 1'b1); tick();
        check("R12 four 5-bit words form B word 2", 32'(qb_rdata),
              {12'h0, 5'h03, 5'h1E, 5'h07, 5'h11});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin : main
        #2 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_preload();
        t_mapping();
        t_lanes();
        t_ren();
        t_modes();
        t_cross();
        t_aligned_map();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule